// File: doc/BRIEF.md
# Pixel Matrix Column Readout Serializer

This block sits at the edge of a photon-counting pixel matrix and moves data between the matrix and the chip ports. The matrix has `NCOL` columns. Each column is a serial chain of `ROWS * BITS` bits. The columns share a shift pulse, and each column offers one head bit and takes one input bit. A column-wide staging register sits between the columns and the ports. In a read frame, each step pulses every column once and captures one head bit per column. The register is then emptied either as a serial bit stream or as `WORD`-bit words. In a write frame, the register is filled from a serial input stream and then pushed into every column with one shift pulse.

The data streams use valid/ready handshakes. A beat transfers on a rising edge where both valid and ready are high. While the sink holds ready low, the block keeps valid high and keeps the data unchanged. The serial input stream accepts a bit only while its ready is high. The control pins `start`, `dir_wr`, `par_sel`, `busy` and `done` carry no handshake. A frame runs `ROWS * BITS` steps, so the defaults give 3328 steps and 851968 bits in total.

Top module: `pxm_readout`

## Requirements
- R1: After reset `busy`, `done`, `ser_valid`, `par_valid` and `sin_ready` are 0, and every bit of `col_clk` is 0.
- R2: A read step raises all `col_clk` bits together for exactly one cycle. The staging register takes `col_dout` as it stands in that cycle, so column c's head bit is captured before the column advances.
- R3: With `par_sel`=0 in a read frame, each step is unloaded as `NCOL` beats on `ser_data`. Beat i carries the bit captured from column i, starting with column 0.
- R4: With `par_sel`=1 in a read frame, each step is unloaded as `NCOL/WORD` beats on `par_data`. Beat k carries columns k*WORD to k*WORD+WORD-1, with column k*WORD on bit 0.
- R5: While an output valid is high and its ready is low, the valid stays high and the data stays unchanged on the next cycle, and no beat is lost.
- R6: A frame has exactly `ROWS*BITS` steps, so each column gets exactly that many `col_clk` pulses. After the last beat, `done` is high for exactly one cycle and `busy` is 0 in that cycle.
- R7: `dir_wr`=1 starts a write frame. Each step accepts `NCOL` beats on `sin_data`, and beat i is destined for column i. The step then gives one `col_clk` pulse while `col_din[i]` holds beat i.
- R8: Matrix writes use only the serial input. In a write frame `par_sel` is ignored, and `ser_valid` and `par_valid` stay 0.
- R9: `start` is ignored while `busy` is 1. The running frame keeps its direction, mode and data order.
- R10: A `start` in the cycle where `done` is high is accepted, and `busy` is 1 on the next cycle.
- R11: During a read frame `sin_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| dir_wr | input | 1 | Frame direction: 1 writes the matrix, 0 reads it |
| par_sel | input | 1 | Read unload width: 1 word-wide, 0 serial |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| col_clk | output | NCOL | Shift pulse for every column chain |
| col_dout | input | NCOL | Head bit of each column chain |
| col_din | output | NCOL | Bit shifted into each column chain |
| ser_valid | output | 1 | Serial output beat valid |
| ser_ready | input | 1 | Serial output sink ready |
| ser_data | output | 1 | Serial output bit |
| par_valid | output | 1 | Word output beat valid |
| par_ready | input | 1 | Word output sink ready |
| par_data | output | WORD | Word output data |
| sin_valid | input | 1 | Serial input beat valid |
| sin_ready | output | 1 | Serial input accepted when high |
| sin_data | input | 1 | Serial input bit |

## Verification
Two functions can land in the same cycle: the end of one frame and the start of the next. The bench raises `start` in the very cycle `done` is observed and expects `busy` on the next cycle. It then expects the following frame to unload fresh column data in the new mode. A second overlap comes from a `start` with write direction pulsed in the middle of a back-pressured read. It is judged by full agreement of the read data, by `sin_ready` staying low, and by the frame ending with the correct step count.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAP,
    ST_UNLD,
    ST_LOAD,
    ST_PUSH
  } pxm_state_e;
endpackage

// File: rtl/pxm_seq.sv
module pxm_seq #(
  parameter int NCOL = 256,
  parameter int WORD = 32,
  parameter int ROWS = 256,
  parameter int BITS = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  dir_wr,
  input  logic                  par_sel,
  input  logic                  out_fire,
  input  logic                  in_fire,
  output pxm_pkg::pxm_state_e   state_q,
  output logic                  par_q,
  output logic                  busy,
  output logic                  done
);
  import pxm_pkg::*;

  localparam int FRAME = ROWS * BITS;
  localparam int SW    = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam int BW    = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam logic [BW-1:0] LAST_SER = BW'(NCOL - 1);
  localparam logic [BW-1:0] LAST_PAR = BW'(NCOL / WORD - 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(FRAME - 1);

  logic [SW-1:0] step_q;
  logic [BW-1:0] beat_q;
  logic [BW-1:0] last_beat;
  logic          last_step;

  assign last_beat = par_q ? LAST_PAR : LAST_SER;
  assign last_step = (step_q == LAST_STEP);
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      beat_q  <= '0;
      par_q   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            par_q   <= par_sel & ~dir_wr;
            step_q  <= '0;
            beat_q  <= '0;
            state_q <= dir_wr ? ST_LOAD : ST_CAP;
          end
        end
        ST_CAP: begin
          beat_q  <= '0;
          state_q <= ST_UNLD;
        end
        ST_UNLD: begin
          if (out_fire) begin
            if (beat_q == last_beat) begin
              beat_q <= '0;
              if (last_step) begin
                state_q <= ST_IDLE;
                done    <= 1'b1;
              end else begin
                step_q  <= step_q + 1'b1;
                state_q <= ST_CAP;
              end
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (in_fire) begin
            if (beat_q == LAST_SER) begin
              beat_q  <= '0;
              state_q <= ST_PUSH;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        ST_PUSH: begin
          if (last_step) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: the end-of-frame flag lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: a capture pulse is always followed by unloading
  a_r2_cap_then_unload: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAP) |=> (state_q == ST_UNLD));

  // R9: a stalled unload ignores start and keeps its mode
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNLD) && start && !out_fire |=> (state_q == ST_UNLD) && $stable(par_q));

  // R7: a push pulse only follows a completed load
  a_r7_push_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH) |-> ($past(state_q) == ST_LOAD) && $past(in_fire));
endmodule

// File: rtl/pxm_capreg.sv
module pxm_capreg #(
  parameter int NCOL = 256,
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [NCOL-1:0] cap_bits,
  input  logic            ser_adv,
  input  logic            par_adv,
  input  logic            in_adv,
  input  logic            in_bit,
  output logic [NCOL-1:0] reg_q
);
  logic [NCOL-1:0] ser_next;
  logic [NCOL-1:0] par_next;

  generate
    for (genvar i = 0; i < NCOL; i++) begin : g_bit
      if (i == NCOL - 1) begin : g_top
        assign ser_next[i] = in_bit & in_adv;
      end else begin : g_mid
        assign ser_next[i] = reg_q[i+1];
      end
      if (i + WORD < NCOL) begin : g_wsh
        assign par_next[i] = reg_q[i+WORD];
      end else begin : g_wfill
        assign par_next[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (cap_en) begin
      reg_q <= cap_bits;
    end else if (par_adv) begin
      reg_q <= par_next;
    end else if (ser_adv || in_adv) begin
      reg_q <= ser_next;
    end
  end

  // R2: capture takes the column head bits of the pulse cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (reg_q == $past(cap_bits)));

  // R7: an accepted input bit enters at the top end
  a_r7_insert: assert property (@(posedge clk) disable iff (!rst_n)
    in_adv && !cap_en |=> (reg_q[NCOL-1] == $past(in_bit)));

  // R3: a serial beat moves the next column into the output slot
  a_r3_ser_step: assert property (@(posedge clk) disable iff (!rst_n)
    ser_adv && !cap_en && !par_adv |=> (reg_q[0] == $past(reg_q[1])));

  generate
    if (NCOL >= 2 * WORD) begin : g_wchk
      // R4: a word beat moves the next column group into the output slot
      a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        par_adv && !cap_en |=> (reg_q[WORD-1:0] == $past(reg_q[2*WORD-1:WORD])));
    end
  endgenerate
endmodule

// File: rtl/pxm_readout.sv
module pxm_readout #(
  parameter int NCOL = 256,
  parameter int WORD = 32,
  parameter int ROWS = 256,
  parameter int BITS = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dir_wr,
  input  logic            par_sel,
  output logic            busy,
  output logic            done,
  output logic [NCOL-1:0] col_clk,
  input  logic [NCOL-1:0] col_dout,
  output logic [NCOL-1:0] col_din,
  output logic            ser_valid,
  input  logic            ser_ready,
  output logic            ser_data,
  output logic            par_valid,
  input  logic            par_ready,
  output logic [WORD-1:0] par_data,
  input  logic            sin_valid,
  output logic            sin_ready,
  input  logic            sin_data
);
  import pxm_pkg::*;

  pxm_state_e      state_q;
  logic            par_q;
  logic            ser_fire;
  logic            par_fire;
  logic            in_fire;
  logic            pulse;
  logic [NCOL-1:0] reg_q;

  assign ser_valid = (state_q == ST_UNLD) && !par_q;
  assign par_valid = (state_q == ST_UNLD) && par_q;
  assign sin_ready = (state_q == ST_LOAD);
  assign ser_fire  = ser_valid && ser_ready;
  assign par_fire  = par_valid && par_ready;
  assign in_fire   = sin_valid && sin_ready;
  assign pulse     = (state_q == ST_CAP) || (state_q == ST_PUSH);
  assign col_clk   = {NCOL{pulse}};
  assign col_din   = reg_q;
  assign ser_data  = reg_q[0];
  assign par_data  = reg_q[WORD-1:0];

  pxm_seq #(.NCOL(NCOL), .WORD(WORD), .ROWS(ROWS), .BITS(BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dir_wr   (dir_wr),
    .par_sel  (par_sel),
    .out_fire (ser_fire || par_fire),
    .in_fire  (in_fire),
    .state_q  (state_q),
    .par_q    (par_q),
    .busy     (busy),
    .done     (done)
  );

  pxm_capreg #(.NCOL(NCOL), .WORD(WORD)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (state_q == ST_CAP),
    .cap_bits (col_dout),
    .ser_adv  (ser_fire),
    .par_adv  (par_fire),
    .in_adv   (in_fire),
    .in_bit   (sin_data),
    .reg_q    (reg_q)
  );

  // R5: a stalled serial beat is held unchanged
  a_r5_ser_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid && !ser_ready |=> ser_valid && $stable(ser_data));

  // R5: a stalled word beat is held unchanged
  a_r5_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid && !par_ready |=> par_valid && $stable(par_data));

  // R2: a column pulse lasts one cycle
  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    col_clk[0] |=> !col_clk[0]);
endmodule

// File: tb/sim_pxm_readout.sv
module sim_pxm_readout;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 8;
  localparam int WORD = 4;
  localparam int ROWS = 2;
  localparam int BITS = 3;
  localparam int FRAME = ROWS * BITS;
  localparam int NWRD = NCOL / WORD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_wr = 1'b0, par_sel = 1'b0;
  logic busy, done;
  logic [NCOL-1:0] col_clk, col_dout, col_din;
  logic ser_valid, ser_data, par_valid, sin_ready;
  logic ser_ready = 1'b1, par_ready = 1'b1;
  logic [WORD-1:0] par_data;
  logic sin_valid = 1'b0, sin_data = 1'b0;

  int total = 0, fails = 0;
  int cnt [NCOL];
  int base = 0, rd_col = 0, rd_word = 0, rd_step = 0, wstep = 0, cyc = 0;
  bit rd_active = 0, wr_active = 0, bp = 0;
  bit hold_s = 0, hold_p = 0, hold_sd = 0;
  logic [WORD-1:0] hold_pd = '0;
  int stray_in = 0, stray_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxm_readout #(.NCOL(NCOL), .WORD(WORD), .ROWS(ROWS), .BITS(BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr), .par_sel(par_sel),
    .busy(busy), .done(done), .col_clk(col_clk), .col_dout(col_dout), .col_din(col_din),
    .ser_valid(ser_valid), .ser_ready(ser_ready), .ser_data(ser_data),
    .par_valid(par_valid), .par_ready(par_ready), .par_data(par_data),
    .sin_valid(sin_valid), .sin_ready(sin_ready), .sin_data(sin_data)
  );

  function automatic logic pat(input int c, input int s);
    return ((c * 3 + s * 5 + c * s) % 7) < 3;
  endfunction

  function automatic logic wpat(input int c, input int s);
    return ((c * 11 + s * 2) % 5) >= 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // column chain model: head bit advances on each shift pulse
  always_ff @(posedge clk) begin
    for (int c = 0; c < NCOL; c++) begin
      if (!rst_n) cnt[c] <= 0;
      else if (col_clk[c]) cnt[c] <= cnt[c] + 1;
    end
  end

  always_comb begin
    for (int c = 0; c < NCOL; c++) col_dout[c] = pat(c, cnt[c]);
  end

  always begin
    @(posedge clk);
    #1;
    cyc++;
    ser_ready = bp ? ((cyc % 3) != 0) : 1'b1;
    par_ready = bp ? ((cyc % 4) != 1) : 1'b1;
  end

  always @(negedge clk) begin
    if (hold_s) chk(ser_valid && ser_data == hold_sd, "R5 serial hold", ser_data, hold_sd);
    if (hold_p) chk(par_valid && par_data == hold_pd, "R5 word hold", par_data, hold_pd);
    hold_s = ser_valid && !ser_ready;
    hold_sd = ser_data;
    hold_p = par_valid && !par_ready;
    hold_pd = par_data;
    if (rd_active && sin_ready) stray_in++;
    if (wr_active && (ser_valid || par_valid)) stray_out++;
    if (rd_active && ser_valid && ser_ready) begin
      chk(ser_data == pat(rd_col, base + rd_step), "R3 serial bit", ser_data, pat(rd_col, base + rd_step));
      rd_col++;
      if (rd_col == NCOL) begin rd_col = 0; rd_step++; end
    end
    if (rd_active && par_valid && par_ready) begin
      logic [WORD-1:0] e;
      for (int k = 0; k < WORD; k++) e[k] = pat(rd_word * WORD + k, base + rd_step);
      chk(par_data == e, "R4 word", par_data, e);
      rd_word++;
      if (rd_word == NWRD) begin rd_word = 0; rd_step++; end
    end
    if (wr_active && col_clk[0]) begin
      logic [NCOL-1:0] e;
      for (int c = 0; c < NCOL; c++) e[c] = wpat(c, wstep);
      chk(col_din == e, "R7 pushed bits", col_din, e);
      chk(col_clk == {NCOL{1'b1}}, "R2 all columns pulsed", col_clk, {NCOL{1'b1}});
      wstep++;
    end
  end

  task automatic begin_read(input bit par);
    base = cnt[0];
    rd_col = 0; rd_word = 0; rd_step = 0; stray_in = 0;
    rd_active = 1;
    start = 1'b1; dir_wr = 1'b0; par_sel = par;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic finish_read(input string tag);
    do @(negedge clk); while (!done);
    rd_active = 0;
    chk(rd_step == FRAME, {tag, " R6 steps unloaded"}, rd_step, FRAME);
    chk(cnt[0] - base == FRAME, {tag, " R6 column pulses"}, cnt[0] - base, FRAME);
    chk(!busy, {tag, " R6 idle at done"}, busy, 0);
    chk(stray_in == 0, {tag, " R11 no input ready"}, stray_in, 0);
  endtask

  task automatic run_write(input bit par);
    wstep = 0; stray_out = 0; wr_active = 1;
    @(posedge clk); #1;
    start = 1'b1; dir_wr = 1'b1; par_sel = par;
    @(posedge clk); #1;
    start = 1'b0; dir_wr = 1'b0;
    for (int s = 0; s < FRAME; s++) begin
      for (int c = 0; c < NCOL; c++) begin
        if (c % 3 == 2) begin sin_valid = 1'b0; @(posedge clk); #1; end
        sin_valid = 1'b1; sin_data = wpat(c, s);
        do @(negedge clk); while (!sin_ready);
        @(posedge clk); #1;
      end
      sin_valid = 1'b0;
    end
    do @(negedge clk); while (!done);
    wr_active = 0;
    chk(wstep == FRAME, "R7 push steps", wstep, FRAME);
    chk(stray_out == 0, "R8 no output beats in write", stray_out, 0);
    chk(!busy, "R6 write idle at done", busy, 0);
    @(negedge clk);
    chk(!done, "R6 write done single", done, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    chk(!ser_valid && !par_valid && !sin_ready, "R1 streams", {ser_valid, par_valid, sin_ready}, 0);
    chk(col_clk == '0, "R1 col_clk", col_clk, 0);

    // serial read, free-running sink
    @(posedge clk); #1;
    begin_read(1'b0);
    finish_read("ser");
    @(negedge clk);
    chk(!done, "R6 done single", done, 0);

    // word read under back-pressure
    bp = 1;
    @(posedge clk); #1;
    begin_read(1'b1);
    finish_read("par-bp");

    // serial read under back-pressure with a stray write start mid-frame (R9)
    @(posedge clk); #1;
    begin_read(1'b0);
    fork
      begin
        repeat (15) @(posedge clk);
        #1 start = 1'b1; dir_wr = 1'b1; par_sel = 1'b1;
        @(posedge clk);
        #1 start = 1'b0; dir_wr = 1'b0; par_sel = 1'b0;
      end
    join_none
    finish_read("R9 ser-bp");

    // R10: start in the done cycle, chained into a word read
    begin_read_at_done();
    bp = 0;

    // write frames, serial input only, par_sel ignored (R8)
    run_write(1'b0);
    run_write(1'b1);

    // read after write still works
    @(posedge clk); #1;
    begin_read(1'b1);
    finish_read("par-after-write");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic begin_read_at_done();
    @(posedge clk); #1;
    begin_read(1'b0);
    do @(negedge clk); while (!done);
    rd_active = 0;
    chk(rd_step == FRAME, "R10 first frame steps", rd_step, FRAME);
    begin_read(1'b1);
    @(negedge clk);
    chk(busy, "R10 start at done accepted", busy, 1);
    finish_read("R10 chained par");
  endtask
endmodule